// File: doc/BRIEF.md
# I2C Master Start-Condition Generator

This block produces the opening Start condition of an I2C transfer for a bus master. Software raises a one-cycle start request. The block checks that both bus lines are idle-high. It then waits one baud period, pulls SDA low while SCL is still high, and waits a second baud period. After that it reports completion and keeps SDA held low for the data phase that follows. One baud period lasts (reload + 1) clock cycles and is timed by a down-counter that is reloaded from an 8-bit value at the start of each period.

Both bus lines are sampled through a synchronizer and are never driven high. SCL is only observed. SDA is driven only by a pull-low enable. A collision is declared in two cases: either line reads low when the request arrives, or either line drops during the first period before SDA has been pulled. On a collision the block gives up the Start, releases SDA and returns to idle. The completion flag and the collision flag stay set until software clears each one with its own write-one-to-clear pulse.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, `sda_pull`, `start_en`, `start_seen`, `done_flag` and `coll_flag` are all 0.
- R2: A `start_req` pulse seen at a clock edge while idle, with both synchronized lines high, sets `start_en` after that edge and loads the baud counter with `reload`.
- R3: `sda_pull` and `start_seen` rise exactly `reload`+1 clock edges after the accepting edge. `sda_pull` stays 0 before that.
- R4: Exactly `reload`+1 edges after `sda_pull` rises, `start_en` falls and `done_flag` rises, while `sda_pull` remains 1.
- R5: A `start_req` pulse while idle with either synchronized line low sets `coll_flag`. `start_en` and `sda_pull` stay 0.
- R6: If either line goes low during the first baud period, `coll_flag` rises on the third clock edge after the change at the pins. At the same time `start_en` is 0 and `sda_pull` is still 0. The block is idle again and accepts a new request.
- R7: A `start_req` pulse while a Start is in progress or completed is ignored. It changes neither the timing nor any output.
- R8: `done_flag` and `coll_flag` stay set until a 1 on their own clear input (`clr_done`, `clr_coll`). A clear input has no effect on the other flag.
- R9: `sda_in` and `scl_in` pass through a two-stage synchronizer that resets to 1 (bus idle) before the sequencer samples them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle software request to begin a Start |
| reload | input | 8 | Baud reload value; period is reload+1 cycles |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| clr_done | input | 1 | Write-one-to-clear for `done_flag` |
| clr_coll | input | 1 | Write-one-to-clear for `coll_flag` |
| sda_pull | output | 1 | 1 = open-drain driver pulls SDA low |
| start_en | output | 1 | Start-enable bit, cleared by hardware |
| start_seen | output | 1 | Start condition has been made on the bus |
| done_flag | output | 1 | Completion interrupt flag |
| coll_flag | output | 1 | Bus-collision flag |

## Verification
A table of reload values and bus-line levels runs the main sequence. Reloads of 0, 1, 6 and 255 confirm that both periods scale as reload+1 and that neither period is off by one. Bus states with SDA low, SCL low, or both low at request time each have to produce a collision instead of a Start. Directed runs drop SCL partway through the first period, which shows the synchronizer latency and the clean abort. They also repeat the request during and after the sequence to show it is ignored, and clear each flag separately to show the clears are independent.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_LEAD    = 2'd1,
      ST_HOLDOFF = 2'd2,
      ST_HELD    = 2'd3
   } seq_state_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("i2cs_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] pipe;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= RST_VAL;
         else        pipe <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= {STAGES{RST_VAL}};
         else        pipe <= {pipe[STAGES-2:0], d};
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/i2cs_baud_cnt.sv
module i2cs_baud_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         halt,
   input  logic [W-1:0] reload,
   output logic         expire
);

   if (W < 1) begin : g_bad_width
      $error("i2cs_baud_cnt: W must be at least 1");
   end

   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = W'(1);

   logic [W-1:0] cnt;
   logic         active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= ZERO;
         active <= 1'b0;
      end else if (load) begin
         cnt    <= reload;
         active <= 1'b1;
      end else if (halt) begin
         active <= 1'b0;
      end else if (active && cnt != ZERO) begin
         cnt <= cnt - ONE;
      end
   end

   assign expire = active && (cnt == ZERO);

   // R3: a running period steps down by exactly one per cycle
   a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !load && !halt && cnt != ZERO) |=> (cnt == $past(cnt) - ONE));

   // R2: a load always takes the reload value
   a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (active && cnt == $past(reload)));

endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
   import i2cs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic sda_s,
   input  logic scl_s,
   input  logic expire,
   input  logic clr_done,
   input  logic clr_coll,
   output logic cnt_load,
   output logic cnt_halt,
   output logic sda_pull,
   output logic start_en,
   output logic start_seen,
   output logic done_flag,
   output logic coll_flag
);

   seq_state_t state, state_nx;
   logic       bus_idle;
   logic       done_set, coll_set;
   logic       pull_set, en_set, en_clr;

   assign bus_idle = sda_s & scl_s;

   always_comb begin
      state_nx = state;
      cnt_load = 1'b0;
      cnt_halt = 1'b0;
      done_set = 1'b0;
      coll_set = 1'b0;
      pull_set = 1'b0;
      en_set   = 1'b0;
      en_clr   = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start_req) begin
               if (bus_idle) begin
                  cnt_load = 1'b1;
                  en_set   = 1'b1;
                  state_nx = ST_LEAD;
               end else begin
                  coll_set = 1'b1;
               end
            end
         end
         ST_LEAD: begin
            if (!bus_idle) begin
               coll_set = 1'b1;
               cnt_halt = 1'b1;
               en_clr   = 1'b1;
               state_nx = ST_IDLE;
            end else if (expire) begin
               cnt_load = 1'b1;
               pull_set = 1'b1;
               state_nx = ST_HOLDOFF;
            end
         end
         ST_HOLDOFF: begin
            if (expire) begin
               cnt_halt = 1'b1;
               en_clr   = 1'b1;
               done_set = 1'b1;
               state_nx = ST_HELD;
            end
         end
         default: begin
            state_nx = ST_HELD;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         sda_pull   <= 1'b0;
         start_en   <= 1'b0;
         start_seen <= 1'b0;
         done_flag  <= 1'b0;
         coll_flag  <= 1'b0;
      end else begin
         state <= state_nx;
         if (pull_set) begin
            sda_pull   <= 1'b1;
            start_seen <= 1'b1;
         end
         if (en_set)      start_en <= 1'b1;
         else if (en_clr) start_en <= 1'b0;
         if (done_set)      done_flag <= 1'b1;
         else if (clr_done) done_flag <= 1'b0;
         if (coll_set)      coll_flag <= 1'b1;
         else if (clr_coll) coll_flag <= 1'b0;
      end
   end

   // R3: SDA is pulled only once the Start has been recorded
   a_r3_pull_after_seen: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull |-> start_seen);

   // R4: completion drops the enable and keeps SDA low
   a_r4_done_releases_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> (!start_en && sda_pull));

   // R6: a collision never leaves SDA pulled or the enable set
   a_r6_coll_abort: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(coll_flag) |-> (!sda_pull && !start_en));

   // R4: once held, SDA stays held
   a_r4_pull_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull |=> sda_pull);

   // R8: a flag with no set and no clear keeps its value
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !clr_done) |=> done_flag);

   a_r8_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_flag && !clr_coll) |=> coll_flag);

   // R7: the enable rises only out of idle
   a_r7_en_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_en) |-> ($past(state) == ST_IDLE));

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen #(
   parameter int RELOAD_W    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_req,
   input  logic [RELOAD_W-1:0] reload,
   input  logic                sda_in,
   input  logic                scl_in,
   input  logic                clr_done,
   input  logic                clr_coll,
   output logic                sda_pull,
   output logic                start_en,
   output logic                start_seen,
   output logic                done_flag,
   output logic                coll_flag
);

   if (RELOAD_W < 1 || RELOAD_W > 32) begin : g_bad_reload_w
      $error("i2c_start_gen: RELOAD_W out of range 1..32");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("i2c_start_gen: SYNC_STAGES must be at least 1");
   end

   logic sda_s, scl_s;
   logic cnt_load, cnt_halt, expire;

   i2cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sda_in),
      .q     (sda_s)
   );

   i2cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (scl_s)
   );

   i2cs_baud_cnt #(.W(RELOAD_W)) u_baud (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cnt_load),
      .halt   (cnt_halt),
      .reload (reload),
      .expire (expire)
   );

   i2cs_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (start_req),
      .sda_s      (sda_s),
      .scl_s      (scl_s),
      .expire     (expire),
      .clr_done   (clr_done),
      .clr_coll   (clr_coll),
      .cnt_load   (cnt_load),
      .cnt_halt   (cnt_halt),
      .sda_pull   (sda_pull),
      .start_en   (start_en),
      .start_seen (start_seen),
      .done_flag  (done_flag),
      .coll_flag  (coll_flag)
   );

endmodule

// File: tb/tb_i2c_start_gen.sv
`timescale 1ns/1ps
module tb_i2c_start_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_req = 1'b0;
   logic [7:0] reload = 8'd0;
   logic       sda_in = 1'b1;
   logic       scl_in = 1'b1;
   logic       clr_done = 1'b0;
   logic       clr_coll = 1'b0;
   logic       sda_pull, start_en, start_seen, done_flag, coll_flag;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   i2c_start_gen dut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .reload(reload),
      .sda_in(sda_in), .scl_in(scl_in), .clr_done(clr_done), .clr_coll(clr_coll),
      .sda_pull(sda_pull), .start_en(start_en), .start_seen(start_seen),
      .done_flag(done_flag), .coll_flag(coll_flag)
   );

   // {reload[10:3], sda[2], scl[1], expect_collision[0]}
   localparam int NVEC = 7;
   localparam logic [10:0] VEC [NVEC] = '{
      {8'd0,   1'b1, 1'b1, 1'b0},
      {8'd1,   1'b1, 1'b1, 1'b0},
      {8'd6,   1'b1, 1'b1, 1'b0},
      {8'd255, 1'b1, 1'b1, 1'b0},
      {8'd4,   1'b0, 1'b0, 1'b1},
      {8'd4,   1'b1, 1'b0, 1'b1},
      {8'd4,   1'b0, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic do_reset(input logic sda, input logic scl);
      @(negedge clk);
      rst_n = 1'b0;
      sda_in = sda;
      scl_in = scl;
      start_req = 1'b0;
      clr_done = 1'b0;
      clr_coll = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(3);
   endtask

   // leaves the bench at the falling edge after the accepting edge
   task automatic pulse_req();
      start_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_req = 1'b0;
   endtask

   task automatic pulse_clr(input logic d, input logic c);
      clr_done = d;
      clr_coll = c;
      @(posedge clk);
      @(negedge clk);
      clr_done = 1'b0;
      clr_coll = 1'b0;
   endtask

   initial begin
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset(1'b1, 1'b1);
      chk("R1", "sda_pull", sda_pull, 1'b0);
      chk("R1", "start_en", start_en, 1'b0);
      chk("R1", "start_seen", start_seen, 1'b0);
      chk("R1", "done_flag", done_flag, 1'b0);
      chk("R1", "coll_flag", coll_flag, 1'b0);

      // Vector table: main sequence and request-time collisions
      for (int v = 0; v < NVEC; v++) begin
         int r;
         r = int'(VEC[v][10:3]);
         reload = VEC[v][10:3];
         do_reset(VEC[v][2], VEC[v][1]);
         pulse_req();
         if (VEC[v][0]) begin
            chk("R5", "coll_flag", coll_flag, 1'b1);
            chk("R5", "start_en", start_en, 1'b0);
            chk("R5", "sda_pull", sda_pull, 1'b0);
         end else begin
            chk("R2", "start_en", start_en, 1'b1);
            tick(r);
            chk("R3", "sda_pull early", sda_pull, 1'b0);
            tick(1);
            chk("R3", "sda_pull", sda_pull, 1'b1);
            chk("R3", "start_seen", start_seen, 1'b1);
            tick(r);
            chk("R4", "start_en before end", start_en, 1'b1);
            chk("R4", "done early", done_flag, 1'b0);
            tick(1);
            chk("R4", "start_en", start_en, 1'b0);
            chk("R4", "done_flag", done_flag, 1'b1);
            chk("R4", "sda_pull held", sda_pull, 1'b1);
         end
      end

      // R6 + R9: SCL drops mid-period, seen after two sync stages
      reload = 8'd20;
      do_reset(1'b1, 1'b1);
      pulse_req();
      tick(4);
      scl_in = 1'b0;
      tick(2);
      chk("R9", "coll before sync delay", coll_flag, 1'b0);
      tick(1);
      chk("R6", "coll_flag", coll_flag, 1'b1);
      chk("R6", "start_en", start_en, 1'b0);
      chk("R6", "sda_pull", sda_pull, 1'b0);
      scl_in = 1'b1;
      tick(3);
      pulse_req();
      chk("R6", "re-accept after abort", start_en, 1'b1);
      // R8 coll flag sticky, cleared by its own input only
      tick(5);
      chk("R8", "coll sticky", coll_flag, 1'b1);
      pulse_clr(1'b1, 1'b0);
      chk("R8", "clr_done leaves coll", coll_flag, 1'b1);
      pulse_clr(1'b0, 1'b1);
      chk("R8", "clr_coll clears", coll_flag, 1'b0);

      // R7: extra request mid-sequence does not restart the count
      reload = 8'd5;
      do_reset(1'b1, 1'b1);
      pulse_req();
      tick(2);
      pulse_req();
      tick(2);
      chk("R7", "sda_pull not yet", sda_pull, 1'b0);
      tick(1);
      chk("R7", "sda_pull on time", sda_pull, 1'b1);
      tick(6);
      chk("R7", "done on time", done_flag, 1'b1);
      // R7: request after completion ignored
      pulse_req();
      tick(2);
      chk("R7", "start_en stays low", start_en, 1'b0);
      chk("R7", "no collision", coll_flag, 1'b0);
      chk("R7", "sda still held", sda_pull, 1'b1);
      // R8 done flag clears
      pulse_clr(1'b0, 1'b1);
      chk("R8", "clr_coll leaves done", done_flag, 1'b1);
      pulse_clr(1'b1, 1'b0);
      chk("R8", "clr_done clears", done_flag, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule